// File: doc/BRIEF.md
# Branch Condition Evaluator

This block decides whether a program sequencer's conditional branch, call or other conditional instruction should take effect. Each cycle it receives the processor's arithmetic status flags (zero, negative, overflow, carry, MAC overflow, shifter input sign), the loop counter expiry signal and an asynchronous external flag pin. It also receives a 4-bit condition code, a flag-condition select bit and a 2-bit instruction class. It produces one registered "condition true" bit and one registered "illegal condition" bit.

Signed comparisons do not look at the negative flag alone. They use negative XOR overflow, so a result that overflowed is still ordered correctly. The external flag pin passes through a configurable synchronizer chain and then through a sample register. The flag conditions test that last registered sample. Flag conditions are only legal on jump and call instructions. On any other instruction class they evaluate false and raise the illegal output.

Top module: `branch_cond_eval`

## Requirements
- R1: With `cond_use_flag`=0, code 0 (equal) is true when `st_zero`=1, and code 1 (not equal) is true when `st_zero`=0.
- R2: With `cond_use_flag`=0, code 4 (less than) is true when `st_neg` XOR `st_ovf` is 1, and code 5 (greater or equal) is true when that XOR is 0.
- R3: With `cond_use_flag`=0, code 3 (less or equal) is true when (`st_neg` XOR `st_ovf`) OR `st_zero` is 1, and code 2 (greater than) is true when that expression is 0.
- R4: With `cond_use_flag`=0, the following codes each test one flag. Code 6 is true on `st_ovf`=1 and code 7 on `st_ovf`=0. Code 8 is true on `st_carry`=1 and code 9 on `st_carry`=0. Code 12 is true on `st_mac_ovf`=1 and code 13 on `st_mac_ovf`=0.
- R5: With `cond_use_flag`=0, code 10 (negative input) is true when `st_shift_sign`=1, and code 11 (positive input) is true when `st_shift_sign`=0.
- R6: With `cond_use_flag`=0, code 14 is true exactly while `loop_expired`=0.
- R7: With `cond_use_flag`=0, code 15 is always true, whatever the status flags are.
- R8: With `cond_use_flag`=1 and `instr_class` equal to jump (2'b01) or call (2'b10), the code's bit 0 chooses the flag condition. Bit 0 = 0 is true when the last flag-pin sample is 1, and bit 0 = 1 is true when that sample is 0. Code bits 3:1 are ignored. The sample comes from `SYNC_STAGES` synchronizer flops and then one sample flop. With the default of 2, a pin change reaches `cond_true` on the 4th rising edge after it and not earlier.
- R9: With `cond_use_flag`=1 and `instr_class` equal to other (2'b00) or return (2'b11), `cond_true` is 0 and `cond_illegal` is 1. In every other case `cond_illegal` is 0, and non-flag codes are evaluated for every class.
- R10: Both outputs are registered: they reflect the inputs present at the preceding rising edge. A synchronous active-high `rst` clears both outputs and the flag sample to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| st_zero | input | 1 | ALU zero flag |
| st_neg | input | 1 | ALU negative flag |
| st_ovf | input | 1 | ALU overflow flag |
| st_carry | input | 1 | ALU carry flag |
| st_mac_ovf | input | 1 | MAC overflow flag |
| st_shift_sign | input | 1 | Shifter X-input sign bit |
| loop_expired | input | 1 | Loop counter expired |
| flag_pin | input | 1 | Asynchronous external flag pin |
| cond_code | input | 4 | Condition code |
| cond_use_flag | input | 1 | Selects a flag-pin condition |
| instr_class | input | 2 | 00 other, 01 jump, 10 call, 11 return |
| cond_true | output | 1 | Registered condition result |
| cond_illegal | output | 1 | Registered illegal flag-condition indication |

## Verification
The signed codes are run through all eight combinations of zero, negative and overflow. This separates a correct XOR-based comparison from one that reads the negative flag alone or that leaves the zero term out of less-or-equal. Each single-flag code is driven with its flag both set and clear, while the other flags are held at values that would flip a result wired to the wrong flag. The flag pin is toggled while a jump flag condition is held, and the result is checked one edge before and at the edge where it is expected, which pins down the synchronizer depth. The same flag conditions are then issued under all four instruction classes, separating the legal classes from the illegal ones.

// File: rtl/bce_pkg.sv
package bce_pkg;

  localparam int CODE_W = 4;

  typedef enum logic [CODE_W-1:0] {
    CC_EQ      = 4'd0,
    CC_NE      = 4'd1,
    CC_GT      = 4'd2,
    CC_LE      = 4'd3,
    CC_LT      = 4'd4,
    CC_GE      = 4'd5,
    CC_AV      = 4'd6,
    CC_NOT_AV  = 4'd7,
    CC_AC      = 4'd8,
    CC_NOT_AC  = 4'd9,
    CC_NEG     = 4'd10,
    CC_POS     = 4'd11,
    CC_MV      = 4'd12,
    CC_NOT_MV  = 4'd13,
    CC_NOT_CE  = 4'd14,
    CC_ALWAYS  = 4'd15
  } cond_code_e;

  typedef enum logic [1:0] {
    IC_OTHER  = 2'b00,
    IC_JUMP   = 2'b01,
    IC_CALL   = 2'b10,
    IC_RETURN = 2'b11
  } instr_class_e;

  typedef struct packed {
    logic zero;
    logic neg;
    logic ovf;
    logic carry;
    logic mac_ovf;
    logic shift_sign;
    logic loop_exp;
  } status_t;

endpackage

// File: rtl/bce_flag_sync.sv
module bce_flag_sync #(
  parameter int   SYNC_STAGES = 2,
  parameter logic RESET_VAL   = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic pin_async,
  output logic sample_q
);

  logic [SYNC_STAGES-1:0] chain_q;

  generate
    if (SYNC_STAGES == 1) begin : g_single
      always_ff @(posedge clk) begin
        if (rst) chain_q <= RESET_VAL;
        else     chain_q <= pin_async;
      end
    end else begin : g_multi
      always_ff @(posedge clk) begin
        if (rst) chain_q <= {SYNC_STAGES{RESET_VAL}};
        else     chain_q <= {chain_q[SYNC_STAGES-2:0], pin_async};
      end
    end
  endgenerate

  // Last registered sample, refreshed every cycle.
  always_ff @(posedge clk) begin
    if (rst) sample_q <= RESET_VAL;
    else     sample_q <= chain_q[SYNC_STAGES-1];
  end

  // R10: sample held at reset value right after reset
  p_sample_reset_r10 : assert property (@(posedge clk)
    rst |=> (sample_q == RESET_VAL))
    else $error("sample not cleared by reset");

endmodule

// File: rtl/bce_arith_eval.sv
module bce_arith_eval
  import bce_pkg::*;
(
  input  status_t           status,
  input  logic [CODE_W-1:0] code,
  output logic              arith_true
);

  logic signed_lt;
  logic signed_le;

  always_comb begin
    signed_lt = status.neg ^ status.ovf;
    signed_le = signed_lt | status.zero;
  end

  always_comb begin
    unique case (cond_code_e'(code))
      CC_EQ:     arith_true =  status.zero;
      CC_NE:     arith_true = ~status.zero;
      CC_GT:     arith_true = ~signed_le;
      CC_LE:     arith_true =  signed_le;
      CC_LT:     arith_true =  signed_lt;
      CC_GE:     arith_true = ~signed_lt;
      CC_AV:     arith_true =  status.ovf;
      CC_NOT_AV: arith_true = ~status.ovf;
      CC_AC:     arith_true =  status.carry;
      CC_NOT_AC: arith_true = ~status.carry;
      CC_NEG:    arith_true =  status.shift_sign;
      CC_POS:    arith_true = ~status.shift_sign;
      CC_MV:     arith_true =  status.mac_ovf;
      CC_NOT_MV: arith_true = ~status.mac_ovf;
      CC_NOT_CE: arith_true = ~status.loop_exp;
      CC_ALWAYS: arith_true = 1'b1;
      default:   arith_true = 1'b0;
    endcase
  end

endmodule

// File: rtl/bce_flag_gate.sv
module bce_flag_gate
  import bce_pkg::*;
(
  input  logic       use_flag,
  input  logic       invert,
  input  logic [1:0] iclass,
  input  logic       flag_sample,
  input  logic       arith_true,
  output logic       true_next,
  output logic       illegal_next
);

  logic class_ok;

  always_comb begin
    class_ok = (instr_class_e'(iclass) == IC_JUMP) ||
               (instr_class_e'(iclass) == IC_CALL);
    if (use_flag) begin
      illegal_next = ~class_ok;
      true_next    = class_ok & (flag_sample ^ invert);
    end else begin
      illegal_next = 1'b0;
      true_next    = arith_true;
    end
  end

endmodule

// File: rtl/branch_cond_eval.sv
module branch_cond_eval
  import bce_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              st_zero,
  input  logic              st_neg,
  input  logic              st_ovf,
  input  logic              st_carry,
  input  logic              st_mac_ovf,
  input  logic              st_shift_sign,
  input  logic              loop_expired,
  input  logic              flag_pin,
  input  logic [CODE_W-1:0] cond_code,
  input  logic              cond_use_flag,
  input  logic [1:0]        instr_class,
  output logic              cond_true,
  output logic              cond_illegal
);

  status_t status;
  logic    flag_sample;
  logic    arith_true;
  logic    true_next;
  logic    illegal_next;

  always_comb begin
    status.zero       = st_zero;
    status.neg        = st_neg;
    status.ovf        = st_ovf;
    status.carry      = st_carry;
    status.mac_ovf    = st_mac_ovf;
    status.shift_sign = st_shift_sign;
    status.loop_exp   = loop_expired;
  end

  bce_flag_sync #(
    .SYNC_STAGES (SYNC_STAGES),
    .RESET_VAL   (1'b0)
  ) u_sync (
    .clk       (clk),
    .rst       (rst),
    .pin_async (flag_pin),
    .sample_q  (flag_sample)
  );

  bce_arith_eval u_arith (
    .status     (status),
    .code       (cond_code),
    .arith_true (arith_true)
  );

  bce_flag_gate u_gate (
    .use_flag     (cond_use_flag),
    .invert       (cond_code[0]),
    .iclass       (instr_class),
    .flag_sample  (flag_sample),
    .arith_true   (arith_true),
    .true_next    (true_next),
    .illegal_next (illegal_next)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      cond_true    <= 1'b0;
      cond_illegal <= 1'b0;
    end else begin
      cond_true    <= true_next;
      cond_illegal <= illegal_next;
    end
  end

  // R9: an illegal flag condition never reports true
  p_illegal_false_r9 : assert property (@(posedge clk) disable iff (rst)
    cond_illegal |-> !cond_true)
    else $error("illegal condition reported true");

  // R9: illegal only follows a flag condition on a non-jump, non-call class
  p_illegal_source_r9 : assert property (@(posedge clk) disable iff (rst)
    cond_illegal |-> $past(cond_use_flag &&
                           instr_class != IC_JUMP && instr_class != IC_CALL))
    else $error("illegal raised without cause");

  // R7: the always code yields true on the next edge
  p_always_true_r7 : assert property (@(posedge clk) disable iff (rst)
    (!cond_use_flag && cond_code == CC_ALWAYS) |=> cond_true)
    else $error("always code not true");

  // R1: equal code tracks the zero flag one edge later
  p_equal_zero_r1 : assert property (@(posedge clk) disable iff (rst)
    (!cond_use_flag && cond_code == CC_EQ) |=> (cond_true == $past(st_zero)))
    else $error("equal code mismatch");

  // R2: less-than code tracks sign xor overflow
  p_less_than_r2 : assert property (@(posedge clk) disable iff (rst)
    (!cond_use_flag && cond_code == CC_LT) |=>
      (cond_true == $past(st_neg ^ st_ovf)))
    else $error("less-than code mismatch");

  // R8: legal flag condition follows the registered pin sample
  p_flag_sample_r8 : assert property (@(posedge clk) disable iff (rst)
    (cond_use_flag && (instr_class == IC_JUMP || instr_class == IC_CALL)) |=>
      (cond_true == $past(flag_sample ^ cond_code[0])))
    else $error("flag condition mismatch");

endmodule

// File: tb/tb_branch_cond_eval.sv
module tb_branch_cond_eval;

  localparam time CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst;
  logic       st_zero, st_neg, st_ovf, st_carry, st_mac_ovf, st_shift_sign;
  logic       loop_expired, flag_pin;
  logic [3:0] cond_code;
  logic       cond_use_flag;
  logic [1:0] instr_class;
  logic       cond_true, cond_illegal;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  branch_cond_eval dut (
    .clk(clk), .rst(rst),
    .st_zero(st_zero), .st_neg(st_neg), .st_ovf(st_ovf), .st_carry(st_carry),
    .st_mac_ovf(st_mac_ovf), .st_shift_sign(st_shift_sign),
    .loop_expired(loop_expired), .flag_pin(flag_pin),
    .cond_code(cond_code), .cond_use_flag(cond_use_flag),
    .instr_class(instr_class),
    .cond_true(cond_true), .cond_illegal(cond_illegal)
  );

  task automatic check(input string req, input logic act, input logic exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %b expected %b", req, act, exp);
    end
  endtask

  task automatic set_flags(input logic [6:0] f);
    {st_zero, st_neg, st_ovf, st_carry, st_mac_ovf, st_shift_sign, loop_expired} = f;
  endtask

  // Drive a non-flag condition at a negedge, check after the next edge.
  task automatic eval_code(input logic [3:0] code, input logic [1:0] cls,
                           input logic exp, input string req);
    cond_code = code; cond_use_flag = 1'b0; instr_class = cls;
    @(posedge clk); @(negedge clk);
    check(req, cond_true, exp);
    check(req, cond_illegal, 1'b0);
  endtask

  task automatic t_reset();
    rst = 1'b1; flag_pin = 1'b1;
    set_flags(7'h7F);
    cond_code = 4'd15; cond_use_flag = 1'b0; instr_class = 2'b01;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R10 reset true", cond_true, 1'b0);
    check("R10 reset illegal", cond_illegal, 1'b0);
    flag_pin = 1'b0;
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic t_zero();
    for (int z = 0; z < 2; z++) begin
      // other flags chosen opposite to zero to expose a miswired flag
      set_flags({z[0], ~z[0], ~z[0], ~z[0], ~z[0], ~z[0], ~z[0]});
      eval_code(4'd0, 2'b00, z[0],  "R1 EQ");
      eval_code(4'd1, 2'b00, ~z[0], "R1 NE");
    end
  endtask

  task automatic t_signed();
    for (int i = 0; i < 8; i++) begin
      logic z, n, v, lt, le;
      {z, n, v} = i[2:0];
      lt = n ^ v;
      le = lt | z;
      set_flags({z, n, v, 4'b0000});
      eval_code(4'd4, 2'b01, lt,  "R2 LT");
      eval_code(4'd5, 2'b01, ~lt, "R2 GE");
      eval_code(4'd3, 2'b10, le,  "R3 LE");
      eval_code(4'd2, 2'b10, ~le, "R3 GT");
    end
  endtask

  task automatic t_single_flags();
    for (int b = 0; b < 2; b++) begin
      logic x;
      x = b[0];
      set_flags({1'b0, ~x, x, ~x, ~x, 1'b0, 1'b0});
      eval_code(4'd6, 2'b00, x,  "R4 AV");
      eval_code(4'd7, 2'b00, ~x, "R4 NOT AV");
      set_flags({1'b0, x, ~x, x, ~x, 1'b0, 1'b0});
      eval_code(4'd8, 2'b11, x,  "R4 AC");
      eval_code(4'd9, 2'b11, ~x, "R4 NOT AC");
      set_flags({1'b0, 1'b0, ~x, ~x, x, 1'b0, 1'b0});
      eval_code(4'd12, 2'b01, x,  "R4 MV");
      eval_code(4'd13, 2'b01, ~x, "R4 NOT MV");
    end
  endtask

  task automatic t_sign_loop();
    for (int b = 0; b < 2; b++) begin
      logic x;
      x = b[0];
      set_flags({~x, ~x, 1'b0, 1'b0, 1'b0, x, ~x});
      eval_code(4'd10, 2'b00, x,  "R5 NEG");
      eval_code(4'd11, 2'b00, ~x, "R5 POS");
      set_flags({x, x, x, x, x, x, x});
      eval_code(4'd14, 2'b10, ~x, "R6 NOT CE");
    end
  endtask

  task automatic t_always();
    set_flags(7'h00);
    eval_code(4'd15, 2'b00, 1'b1, "R7 always flags clear");
    set_flags(7'h7F);
    eval_code(4'd15, 2'b11, 1'b1, "R7 always flags set");
  endtask

  task automatic t_flag_pin();
    set_flags(7'h7F);
    cond_use_flag = 1'b1; instr_class = 2'b01; cond_code = 4'b1110;
    flag_pin = 1'b0;
    repeat (6) @(posedge clk);
    @(negedge clk);
    check("R8 FLAG_IN pin low", cond_true, 1'b0);
    flag_pin = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R8 latency not before 4th edge", cond_true, 1'b0);
    @(posedge clk); @(negedge clk);
    check("R8 latency at 4th edge", cond_true, 1'b1);
    check("R8 legal jump", cond_illegal, 1'b0);
    instr_class = 2'b10; cond_code = 4'b0001;
    @(posedge clk); @(negedge clk);
    check("R8 NOT FLAG_IN call pin high", cond_true, 1'b0);
    flag_pin = 1'b0;
    repeat (5) @(posedge clk);
    @(negedge clk);
    check("R8 NOT FLAG_IN call pin low", cond_true, 1'b1);
    check("R8 legal call", cond_illegal, 1'b0);
  endtask

  task automatic t_illegal();
    flag_pin = 1'b1;
    cond_use_flag = 1'b1; cond_code = 4'b0000;
    repeat (5) @(posedge clk);
    for (int c = 0; c < 4; c++) begin
      logic legal;
      legal = (c == 1) || (c == 2);
      @(negedge clk);
      instr_class = c[1:0];
      @(posedge clk); @(negedge clk);
      check("R9 flag cond true", cond_true, legal);
      check("R9 flag cond illegal", cond_illegal, ~legal);
    end
    set_flags(7'h40);
    eval_code(4'd0, 2'b00, 1'b1, "R9 non-flag code on other class");
  endtask

  task automatic t_registered();
    set_flags(7'h00);
    eval_code(4'd0, 2'b00, 1'b0, "R10 setup");
    st_zero = 1'b1;
    #1;
    check("R10 holds before edge", cond_true, 1'b0);
    @(posedge clk); @(negedge clk);
    check("R10 updates after edge", cond_true, 1'b1);
  endtask

  initial begin
    t_reset();
    t_zero();
    t_signed();
    t_single_flags();
    t_sign_loop();
    t_always();
    t_flag_pin();
    t_illegal();
    t_registered();
    if (!done) begin
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      done = 1'b1;
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

endmodule